// File: doc/BRIEF.md
# Partial-Width Integer Register File

This block holds sixteen 64-bit general-purpose integer registers with one write port and two read ports. Every write names a target register and a write class. The class is a low byte, a high byte, a full 64-bit quad, or the "native" operand size. The native size is settled by the current mode's default operand size together with a size-override prefix flag. The block then combines the incoming value with the old register contents. Narrow writes keep every untouched bit. A 32-bit write clears the upper half. A high-byte write lands in bits 15:8.

The write side also reports two things in the same cycle. The first is the resolved write size. The second is a merge-required flag, raised whenever the write must read back old bits to build the new value. A high-byte write to a register that has no addressable high byte is flagged as illegal and is dropped. Both read ports are combinational and return the contents from before any write in the same cycle.

Top module: `pwrf_top`

## Requirements
- R1: A low-byte write (`wr_cls`=0, resolved `wr_size`=0) replaces bits 7:0 with `wr_data[7:0]` and keeps bits 63:8.
- R2: A high-byte write (`wr_cls`=1, `wr_size`=1) to index 0..3 places `wr_data[7:0]` in bits 15:8 and keeps bits 63:16 and 7:0, so the two byte halves together make up the 16-bit register.
- R3: A 16-bit write (`wr_size`=2) replaces bits 15:0 with `wr_data[15:0]` and keeps bits 63:16.
- R4: A 32-bit write (`wr_size`=3) replaces bits 31:0 with `wr_data[31:0]` and forces bits 63:32 to zero.
- R5: A quad write (`wr_cls`=3, `wr_size`=4) replaces all 64 bits.
- R6: For the native class (`wr_cls`=2), the size is 16 bits when `mode32`=0 and `size_pfx`=0, or when `mode32`=1 and `size_pfx`=1. It is 32 bits in the other two combinations. `wr_size` shows this in the same cycle.
- R7: `merge_req` is high in the same cycle as an accepted write of size 8 or 16 bits (`wr_size` 0, 1 or 2). It is low for 32-bit and 64-bit writes, for illegal writes and when `wr_en` is low.
- R8: A high-byte write to index 4..15 raises `illegal_wr` in the same cycle and changes no register.
- R9: Read ports are combinational. During a write cycle they return the pre-write value, and the new value appears after the clock edge.
- R10: The register index selects the same register whatever the operand size or mode; only the width of the access changes.
- R11: Reset (`rst_n` low) clears all registers to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write request |
| wr_idx | input | 4 | Target register index |
| wr_cls | input | 2 | Write class: 0 low byte, 1 high byte, 2 native, 3 quad |
| mode32 | input | 1 | Mode default operand size: 0 = 16, 1 = 32 |
| size_pfx | input | 1 | Operand-size override prefix present |
| wr_data | input | 64 | Write value, right-aligned |
| rd_a_idx | input | 4 | Read port A index |
| rd_b_idx | input | 4 | Read port B index |
| rd_a_data | output | 64 | Read port A value |
| rd_b_data | output | 64 | Read port B value |
| wr_size | output | 3 | Resolved size: 0 low byte, 1 high byte, 2 16-bit, 3 32-bit, 4 64-bit |
| merge_req | output | 1 | Write needs the old register bits |
| illegal_wr | output | 1 | High-byte write to an index without a high byte |

## Verification
`wr_size`, `merge_req`, `illegal_wr` and both read ports are combinational, so they are due in the same cycle as the stimulus. The bench drives inputs on the falling edge and samples these outputs 1 ns later, well before the rising edge. Register contents change at the next rising edge and are read back through a port 1 ns after that edge. This gives a one-cycle latency from write to visible value. The read-old-value check samples the port while the write is still being driven.

// File: rtl/pwrf_pkg.sv
package pwrf_pkg;
  localparam int XLEN = 64;

  typedef enum logic [2:0] {
    SZ_BLO  = 3'd0,
    SZ_BHI  = 3'd1,
    SZ_WORD = 3'd2,
    SZ_DWRD = 3'd3,
    SZ_QUAD = 3'd4
  } sz_t;

  typedef enum logic [1:0] {
    CLS_BLO  = 2'd0,
    CLS_BHI  = 2'd1,
    CLS_NAT  = 2'd2,
    CLS_QUAD = 2'd3
  } cls_t;

  // Native operand size: prefix inverts the mode default.
  function automatic sz_t native_size(input logic mode32, input logic pfx);
    return (mode32 ^ pfx) ? SZ_DWRD : SZ_WORD;
  endfunction

  // Combine new data with old contents according to size.
  function automatic logic [XLEN-1:0] merge_value(input logic [XLEN-1:0] old,
                                                  input logic [XLEN-1:0] nv,
                                                  input sz_t sz);
    logic [XLEN-1:0] r;
    r = old;
    case (sz)
      SZ_BLO:  r[7:0]  = nv[7:0];
      SZ_BHI:  r[15:8] = nv[7:0];
      SZ_WORD: r[15:0] = nv[15:0];
      SZ_DWRD: r = {{(XLEN-32){1'b0}}, nv[31:0]};
      default: r = nv;
    endcase
    return r;
  endfunction

  function automatic logic keeps_old(input sz_t sz);
    return (sz == SZ_BLO) || (sz == SZ_BHI) || (sz == SZ_WORD);
  endfunction
endpackage

// File: rtl/pwrf_size_sel.sv
module pwrf_size_sel
  import pwrf_pkg::*;
(
  input  logic [1:0] cls,
  input  logic       mode32,
  input  logic       pfx,
  output sz_t        sz
);
  always_comb begin
    case (cls_t'(cls))
      CLS_BLO: sz = SZ_BLO;
      CLS_BHI: sz = SZ_BHI;
      CLS_NAT: sz = native_size(mode32, pfx);
      default: sz = SZ_QUAD;
    endcase
  end
endmodule

// File: rtl/pwrf_merge.sv
module pwrf_merge
  import pwrf_pkg::*;
(
  input  logic [XLEN-1:0] old_val,
  input  logic [XLEN-1:0] new_val,
  input  sz_t             sz,
  output logic [XLEN-1:0] merged,
  output logic            needs_old
);
  always_comb begin
    merged    = merge_value(old_val, new_val, sz);
    needs_old = keeps_old(sz);
  end
endmodule

// File: rtl/pwrf_regs.sv
module pwrf_regs
  import pwrf_pkg::*;
#(
  parameter int NREG = 16,
  localparam int IW  = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [IW-1:0]   widx,
  input  logic [XLEN-1:0] wval,
  input  sz_t             wsz,
  input  logic [IW-1:0]   ra_idx,
  input  logic [IW-1:0]   rb_idx,
  output logic [XLEN-1:0] ra_val,
  output logic [XLEN-1:0] rb_val,
  output logic [XLEN-1:0] tgt_old
);
  logic [NREG-1:0][XLEN-1:0] regs_q;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            regs_q[g] <= '0;
      else if (we && widx == IW'(g))         regs_q[g] <= wval;
    end
  end

  assign ra_val  = regs_q[ra_idx];
  assign rb_val  = regs_q[rb_idx];
  assign tgt_old = regs_q[widx];

  AST_BYTE_LO_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (we && wsz == SZ_BLO) |=> regs_q[$past(widx)][XLEN-1:8] == $past(tgt_old[XLEN-1:8])); // R1
  AST_BYTE_HI_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (we && wsz == SZ_BHI) |=> (regs_q[$past(widx)][XLEN-1:16] == $past(tgt_old[XLEN-1:16]))
                          && (regs_q[$past(widx)][7:0] == $past(tgt_old[7:0]))); // R2
  AST_WORD_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (we && wsz == SZ_WORD) |=> regs_q[$past(widx)][XLEN-1:16] == $past(tgt_old[XLEN-1:16])); // R3
  AST_DWORD_ZERO_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    (we && wsz == SZ_DWRD) |=> regs_q[$past(widx)][XLEN-1:32] == '0); // R4
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(regs_q)); // R8
endmodule

// File: rtl/pwrf_top.sv
module pwrf_top
  import pwrf_pkg::*;
#(
  parameter int NREG   = 16,
  parameter int HI_CNT = 4,
  localparam int IW    = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [IW-1:0]   wr_idx,
  input  logic [1:0]      wr_cls,
  input  logic            mode32,
  input  logic            size_pfx,
  input  logic [XLEN-1:0] wr_data,
  input  logic [IW-1:0]   rd_a_idx,
  input  logic [IW-1:0]   rd_b_idx,
  output logic [XLEN-1:0] rd_a_data,
  output logic [XLEN-1:0] rd_b_data,
  output logic [2:0]      wr_size,
  output logic            merge_req,
  output logic            illegal_wr
);
  sz_t             sz;
  logic            hi_bad;
  logic            wr_fire;
  logic [XLEN-1:0] tgt_old;
  logic [XLEN-1:0] merged;
  logic            needs_old;

  pwrf_size_sel u_sel (
    .cls(wr_cls), .mode32(mode32), .pfx(size_pfx), .sz(sz)
  );

  assign hi_bad     = (sz == SZ_BHI) && (int'(wr_idx) >= HI_CNT);
  assign illegal_wr = wr_en && hi_bad;
  assign wr_fire    = wr_en && !hi_bad;

  pwrf_merge u_merge (
    .old_val(tgt_old), .new_val(wr_data), .sz(sz),
    .merged(merged), .needs_old(needs_old)
  );

  pwrf_regs #(.NREG(NREG)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(wr_fire), .widx(wr_idx), .wval(merged),
    .wsz(sz), .ra_idx(rd_a_idx), .rb_idx(rd_b_idx),
    .ra_val(rd_a_data), .rb_val(rd_b_data), .tgt_old(tgt_old)
  );

  assign wr_size   = sz;
  assign merge_req = wr_fire && needs_old;

  AST_ILLEGAL_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_wr |=> $stable(u_regs.regs_q)); // R8
  AST_MERGE_NARROW_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    merge_req |-> (wr_en && wr_size <= 3'd2 && !illegal_wr)); // R7
  AST_NATIVE_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cls == 2'd2) |-> (wr_size == ((mode32 != size_pfx) ? 3'd3 : 3'd2))); // R6
  AST_QUAD_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_cls == 2'd3) |=> rd_a_idx != $past(wr_idx) || $past(rd_a_idx) != $past(wr_idx)
                                  || rd_a_data == $past(wr_data)); // R5
  AST_ONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({merge_req, illegal_wr}) <= 1); // R7
endmodule

// File: tb/tb_pwrf_top.sv
module tb_pwrf_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        wr_en = 0;
  logic [3:0]  wr_idx = 0;
  logic [1:0]  wr_cls = 0;
  logic        mode32 = 0;
  logic        size_pfx = 0;
  logic [63:0] wr_data = 0;
  logic [3:0]  rd_a_idx = 0;
  logic [3:0]  rd_b_idx = 0;
  logic [63:0] rd_a_data, rd_b_data;
  logic [2:0]  wr_size;
  logic        merge_req, illegal_wr;

  int checks = 0;
  int errors = 0;
  logic [63:0] model [16];

  always #2 clk = ~clk;

  pwrf_top dut (.*);

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Expected size code, worked out from the class and mode table.
  function automatic logic [2:0] exp_size(logic [1:0] c, logic m, logic p);
    if (c == 2'd0) return 3'd0;
    if (c == 2'd1) return 3'd1;
    if (c == 2'd3) return 3'd4;
    if (m == 1'b0) return p ? 3'd3 : 3'd2;
    return p ? 3'd2 : 3'd3;
  endfunction

  // Mask-based model of the write result.
  function automatic logic [63:0] exp_val(logic [63:0] o, logic [63:0] d, logic [2:0] s);
    logic [63:0] keep;
    logic [63:0] ins;
    case (s)
      3'd0: begin keep = ~64'hFF;   ins = d & 64'hFF; end
      3'd1: begin keep = ~64'hFF00; ins = (d & 64'hFF) << 8; end
      3'd2: begin keep = ~64'hFFFF; ins = d & 64'hFFFF; end
      3'd3: begin keep = 64'h0;     ins = d & 64'hFFFF_FFFF; end
      default: begin keep = 64'h0;  ins = d; end
    endcase
    return (o & keep) | ins;
  endfunction

  // One write: checks same-cycle outputs, then the stored value after the edge.
  task automatic wr(string req, int idx, logic [1:0] c, logic m, logic p, logic [63:0] d);
    logic [2:0] s;
    logic bad;
    @(negedge clk);
    wr_en = 1; wr_idx = 4'(idx); wr_cls = c; mode32 = m; size_pfx = p; wr_data = d;
    rd_a_idx = 4'(idx);
    s = exp_size(c, m, p);
    bad = (c == 2'd1) && (idx >= 4);
    #1;
    chk({req, " size"}, 64'(wr_size), 64'(s));
    chk({req, " merge"}, 64'(merge_req), 64'(!bad && s <= 3'd2));
    chk({req, " illegal"}, 64'(illegal_wr), 64'(bad));
    chk({req, " R9 old"}, rd_a_data, model[idx]);
    if (!bad) model[idx] = exp_val(model[idx], d, s);
    @(posedge clk); #1;
    wr_en = 0;
    chk({req, " value"}, rd_a_data, model[idx]);
  endtask

  task automatic rd_chk(string req, int idx);
    @(negedge clk);
    rd_b_idx = 4'(idx);
    #1;
    chk(req, rd_b_data, model[idx]);
  endtask

  task automatic t_reset;
    for (int i = 0; i < 16; i++) begin
      model[i] = '0;
    end
    for (int i = 0; i < 16; i++) begin
      rd_chk("R11 reset zero", i);
    end
    @(negedge clk); #1;
    chk("R7 idle merge", 64'(merge_req), 64'd0);
  endtask

  task automatic t_quad;
    wr("R5 quad", 2, 2'd3, 0, 0, 64'h0123_4567_89AB_CDEF);
    wr("R5 quad b", 9, 2'd3, 1, 1, 64'hFFFF_FFFF_FFFF_FFFF);
  endtask

  task automatic t_low_byte;
    wr("R1 low byte", 2, 2'd0, 0, 0, 64'hDEAD_BEEF_0000_00A5);
    wr("R1 low byte idx9", 9, 2'd0, 1, 1, 64'h0000_0000_0000_0000);
  endtask

  task automatic t_high_byte;
    wr("R2 high byte", 2, 2'd1, 0, 0, 64'h0000_0000_0000_005A);
    wr("R2 high byte idx3", 3, 2'd1, 1, 0, 64'hFFFF_FFFF_FFFF_FF77);
    wr("R2 low byte idx3", 3, 2'd0, 1, 0, 64'h0000_0000_0000_0011);
    rd_chk("R2 halves form word", 3);
    chk("R2 word value", 64'(rd_b_data[15:0]), 64'h7711);
  endtask

  task automatic t_word;
    wr("R3 word", 9, 2'd2, 0, 0, 64'h1111_2222_3333_BEEF);
    wr("R3 word m32 pfx", 9, 2'd2, 1, 1, 64'h0000_0000_0000_1234);
  endtask

  task automatic t_dword;
    wr("R4 dword", 9, 2'd2, 1, 0, 64'hAAAA_AAAA_CAFE_F00D);
    wr("R4 dword m16 pfx", 2, 2'd2, 0, 1, 64'h5555_5555_0BAD_F00D);
    chk("R4 upper zero", rd_a_data[63:32], 64'd0);
  endtask

  task automatic t_mode_sel;
    for (int k = 0; k < 4; k++) begin
      wr("R6 native sel", 5, 2'd2, k[1], k[0], 64'hFEDC_BA98_7654_3210 + 64'(k));
    end
  endtask

  task automatic t_illegal;
    wr("R8 quad seed", 6, 2'd3, 0, 0, 64'h0F0F_0F0F_0F0F_0F0F);
    wr("R8 high byte idx6", 6, 2'd1, 0, 0, 64'hFF);
    wr("R8 high byte idx15", 15, 2'd1, 1, 1, 64'hFF);
    rd_chk("R8 idx6 kept", 6);
  endtask

  task automatic t_numbering;
    wr("R10 m16 word", 7, 2'd2, 0, 0, 64'h0000_0000_0000_ABCD);
    wr("R10 m32 dword", 7, 2'd2, 1, 0, 64'h0000_0000_1234_5678);
    wr("R10 m32 word", 7, 2'd2, 1, 1, 64'h0000_0000_0000_9999);
    rd_chk("R10 same reg", 7);
    rd_chk("R10 neighbour untouched", 8);
  endtask

  task automatic t_read_same_cycle;
    wr("R9 seed", 12, 2'd3, 0, 0, 64'h1);
    @(negedge clk);
    wr_en = 1; wr_idx = 4'd12; wr_cls = 2'd3; wr_data = 64'h2; rd_b_idx = 4'd12;
    #1;
    chk("R9 port B pre-write", rd_b_data, 64'h1);
    @(posedge clk); #1;
    wr_en = 0;
    model[12] = 64'h2;
    chk("R9 port B post-edge", rd_b_data, 64'h2);
  endtask

  initial begin
    fork
      begin
        #1;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;
        t_reset();
        t_quad();
        t_low_byte();
        t_high_byte();
        t_word();
        t_dword();
        t_mode_sel();
        t_illegal();
        t_numbering();
        t_read_same_cycle();
      end
      begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule